// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block sits at the front of a fused multiply-add unit computing `a*b + c`. Each operand arrives already split into a two-bit class and a sign; the addend also brings its biased exponent and fraction. In one registered step, the block decides whether the answer is fixed by the operand classes alone, or whether the full multiply-add arithmetic must run. A fixed answer can be an invalid operation, an infinity, an exact zero, or the addend passed through. For a fixed answer the block delivers the class, sign, exponent and fraction of the result. Otherwise it raises a strobe that hands the operation to the datapath.

Three caller flags shape the signs:
- one negates the addend,
- one negates the product,
- one negates the final result.

These flags act on real results only. They never touch a NaN. A fourth flag halves a normal result by lowering its exponent by one. A two-bit rounding mode sets the sign of an exact zero when two zeros of opposite sign are summed.

When any operand is a NaN, the block does no other work. It raises a request so that separate logic can choose which NaN to return.

Top module: `fma_special_resolve`

## Requirements
- R1: While `rst` is high and after it falls, before any `in_valid`, `out_valid`, `invalid`, `nan_req`, `to_datapath`, `res_sgn`, `res_exp`, `res_frac` are 0 and `res_cls` is 0 (class codes: 0 zero, 1 normal, 2 infinity, 3 NaN).
- R2: A result appears on the outputs and `out_valid` is 1 exactly one clock after the edge that samples `in_valid` high. After an edge with `in_valid` low, `out_valid` is 0 and all result fields hold their previous values.
- R3: If any operand class is 3 (NaN), the result has `nan_req`=1, class 3, sign 0, exponent 0 and fraction 0, with `invalid`=0 and `to_datapath`=0. This holds whatever the other classes and the four flags are.
- R4: A multiplicand pair of infinity and zero (in either order) gives the default NaN: class 3, sign 0, exponent all ones, fraction with only its top bit set, and `invalid`=1. `neg_result` has no effect on it.
- R5: An infinite product plus an infinite addend whose effective sign differs from the product sign gives the default NaN with `invalid`=1. The effective addend sign is `c_sgn ^ neg_addend`. The product sign is `a_sgn ^ b_sgn ^ neg_product`.
- R6: Any other infinite product gives class 2, exponent all ones, fraction 0, and the product sign.
- R7: A finite product with an infinite addend gives class 2, exponent all ones, fraction 0, and the effective addend sign.
- R8: A zero product with a normal addend gives class 1, the addend's exponent and fraction, and the effective addend sign.
- R9: A zero product plus a zero addend gives class 0 with exponent and fraction 0. If the product sign and the effective addend sign differ, the sign is 1 only when `rnd_mode` is 2 (round down), and 0 for modes 0, 1 and 3. If the signs match, the result takes that shared sign.
- R10: `halve_result` lowers the exponent by one on a passed-through normal result. It leaves zero and infinity results unchanged.
- R11: `neg_result` inverts the sign of zero, infinity and passed-through normal results.
- R12: Two normal multiplicands with a zero or normal addend give `to_datapath`=1, class 1, the product sign, exponent 0, fraction 0 and `invalid`=0. `neg_result` and `halve_result` are not applied to this result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and flags are valid this cycle |
| a_cls | input | 2 | Multiplicand A class |
| a_sgn | input | 1 | Multiplicand A sign |
| b_cls | input | 2 | Multiplicand B class |
| b_sgn | input | 1 | Multiplicand B sign |
| c_cls | input | 2 | Addend class |
| c_sgn | input | 1 | Addend sign |
| c_exp | input | EXP_W | Addend biased exponent |
| c_frac | input | FRAC_W | Addend fraction |
| neg_addend | input | 1 | Invert addend sign before evaluation |
| neg_product | input | 1 | Invert product sign |
| neg_result | input | 1 | Invert sign of non-NaN fixed results |
| halve_result | input | 1 | Decrement exponent of a normal fixed result |
| rnd_mode | input | 2 | Rounding mode, 2 = round down |
| out_valid | output | 1 | Result fields are valid |
| res_cls | output | 2 | Result class |
| res_sgn | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent |
| res_frac | output | FRAC_W | Result fraction |
| invalid | output | 1 | Invalid-operation flag |
| nan_req | output | 1 | Request for external NaN selection |
| to_datapath | output | 1 | Result must come from the arithmetic datapath |

## Verification
Every result is due one clock after the edge that samples the operands. The bench drives a stimulus on a falling edge, holds `in_valid` high across one rising edge, drops it on the next falling edge, and reads all outputs at that same falling edge. This is the single point where the registered result is valid and settled.

The hold behaviour is checked one further cycle later. By then no new operation has been sampled, so `out_valid` must be low and the class must be unchanged.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opcls_e;

  typedef enum logic [2:0] {
    K_NANREQ   = 3'd0,
    K_INVALID  = 3'd1,
    K_INF_PROD = 3'd2,
    K_INF_ADD  = 3'd3,
    K_PASS_C   = 3'd4,
    K_ZERO     = 3'd5,
    K_DATAPATH = 3'd6
  } kind_e;

  localparam logic [1:0] RM_DOWN = 2'd2;

endpackage

// File: rtl/fma_sign_prep.sv
module fma_sign_prep (
  input  logic a_sgn,
  input  logic b_sgn,
  input  logic c_sgn,
  input  logic neg_addend,
  input  logic neg_product,
  output logic prod_sgn,
  output logic add_sgn
);
  // Effective signs, formed before any class-based decision.
  always_comb begin
    add_sgn  = c_sgn ^ neg_addend;
    prod_sgn = a_sgn ^ b_sgn ^ neg_product;
  end
endmodule

// File: rtl/fma_case_decode.sv
module fma_case_decode
  import fma_sc_pkg::*;
(
  input  opcls_e a_cls,
  input  opcls_e b_cls,
  input  opcls_e c_cls,
  input  logic   prod_sgn,
  input  logic   add_sgn,
  output kind_e  kind
);
  logic any_nan, ab_inf, ab_zero;

  always_comb begin
    any_nan = (a_cls == CLS_NAN) || (b_cls == CLS_NAN) || (c_cls == CLS_NAN);
    ab_inf  = (a_cls == CLS_INF)  || (b_cls == CLS_INF);
    ab_zero = (a_cls == CLS_ZERO) || (b_cls == CLS_ZERO);

    if (any_nan) begin
      kind = K_NANREQ;
    end else if (ab_inf && ab_zero) begin
      kind = K_INVALID;
    end else if (ab_inf) begin
      // Infinite product: cancels against an opposite infinite addend.
      if ((c_cls == CLS_INF) && (prod_sgn != add_sgn)) kind = K_INVALID;
      else                                             kind = K_INF_PROD;
    end else if (c_cls == CLS_INF) begin
      kind = K_INF_ADD;
    end else if (ab_zero) begin
      kind = (c_cls == CLS_NORM) ? K_PASS_C : K_ZERO;
    end else begin
      kind = K_DATAPATH;
    end
  end
endmodule

// File: rtl/fma_result_form.sv
module fma_result_form
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  kind_e              kind,
  input  logic               prod_sgn,
  input  logic               add_sgn,
  input  logic [EXP_W-1:0]   c_exp,
  input  logic [FRAC_W-1:0]  c_frac,
  input  logic [1:0]         rnd_mode,
  input  logic               halve_result,
  input  logic               neg_result,
  output opcls_e             f_cls,
  output logic               f_sgn,
  output logic [EXP_W-1:0]   f_exp,
  output logic [FRAC_W-1:0]  f_frac,
  output logic               f_inv,
  output logic               f_nreq,
  output logic               f_dp
);
  localparam logic [FRAC_W-1:0] DNAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [EXP_W-1:0]  EXP_ONE   = {{(EXP_W-1){1'b0}}, 1'b1};
  localparam logic [EXP_W-1:0]  EXP_MAX   = {EXP_W{1'b1}};

  logic zero_sgn;

  always_comb begin
    zero_sgn = (prod_sgn != add_sgn) ? (rnd_mode == RM_DOWN) : prod_sgn;

    f_cls  = CLS_NORM;
    f_sgn  = 1'b0;
    f_exp  = '0;
    f_frac = '0;
    f_inv  = 1'b0;
    f_nreq = 1'b0;
    f_dp   = 1'b0;

    unique case (kind)
      K_NANREQ: begin
        f_cls  = CLS_NAN;
        f_nreq = 1'b1;
      end
      K_INVALID: begin
        f_cls  = CLS_NAN;
        f_exp  = EXP_MAX;
        f_frac = DNAN_FRAC;
        f_inv  = 1'b1;
      end
      K_INF_PROD: begin
        f_cls = CLS_INF;
        f_exp = EXP_MAX;
        f_sgn = prod_sgn ^ neg_result;
      end
      K_INF_ADD: begin
        f_cls = CLS_INF;
        f_exp = EXP_MAX;
        f_sgn = add_sgn ^ neg_result;
      end
      K_PASS_C: begin
        f_cls  = CLS_NORM;
        f_exp  = halve_result ? (c_exp - EXP_ONE) : c_exp;
        f_frac = c_frac;
        f_sgn  = add_sgn ^ neg_result;
      end
      K_ZERO: begin
        f_cls = CLS_ZERO;
        f_sgn = zero_sgn ^ neg_result;
      end
      K_DATAPATH: begin
        f_cls = CLS_NORM;
        f_sgn = prod_sgn;
        f_dp  = 1'b1;
      end
      default: begin
        f_cls = CLS_NORM;
      end
    endcase
  end
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        a_cls,
  input  logic              a_sgn,
  input  logic [1:0]        b_cls,
  input  logic              b_sgn,
  input  logic [1:0]        c_cls,
  input  logic              c_sgn,
  input  logic [EXP_W-1:0]  c_exp,
  input  logic [FRAC_W-1:0] c_frac,
  input  logic              neg_addend,
  input  logic              neg_product,
  input  logic              neg_result,
  input  logic              halve_result,
  input  logic [1:0]        rnd_mode,
  output logic              out_valid,
  output logic [1:0]        res_cls,
  output logic              res_sgn,
  output logic [EXP_W-1:0]  res_exp,
  output logic [FRAC_W-1:0] res_frac,
  output logic              invalid,
  output logic              nan_req,
  output logic              to_datapath
);
  logic              prod_sgn, add_sgn;
  kind_e             kind;
  opcls_e            f_cls;
  logic              f_sgn, f_inv, f_nreq, f_dp;
  logic [EXP_W-1:0]  f_exp;
  logic [FRAC_W-1:0] f_frac;

  fma_sign_prep u_sign (
    .a_sgn       (a_sgn),
    .b_sgn       (b_sgn),
    .c_sgn       (c_sgn),
    .neg_addend  (neg_addend),
    .neg_product (neg_product),
    .prod_sgn    (prod_sgn),
    .add_sgn     (add_sgn)
  );

  fma_case_decode u_dec (
    .a_cls    (opcls_e'(a_cls)),
    .b_cls    (opcls_e'(b_cls)),
    .c_cls    (opcls_e'(c_cls)),
    .prod_sgn (prod_sgn),
    .add_sgn  (add_sgn),
    .kind     (kind)
  );

  fma_result_form #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_form (
    .kind         (kind),
    .prod_sgn     (prod_sgn),
    .add_sgn      (add_sgn),
    .c_exp        (c_exp),
    .c_frac       (c_frac),
    .rnd_mode     (rnd_mode),
    .halve_result (halve_result),
    .neg_result   (neg_result),
    .f_cls        (f_cls),
    .f_sgn        (f_sgn),
    .f_exp        (f_exp),
    .f_frac       (f_frac),
    .f_inv        (f_inv),
    .f_nreq       (f_nreq),
    .f_dp         (f_dp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      res_cls     <= 2'd0;
      res_sgn     <= 1'b0;
      res_exp     <= '0;
      res_frac    <= '0;
      invalid     <= 1'b0;
      nan_req     <= 1'b0;
      to_datapath <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_cls     <= f_cls;
        res_sgn     <= f_sgn;
        res_exp     <= f_exp;
        res_frac    <= f_frac;
        invalid     <= f_inv;
        nan_req     <= f_nreq;
        to_datapath <= f_dp;
      end
    end
  end
endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [1:0] a_cls,
  input logic [1:0] b_cls,
  input logic [1:0] c_cls,
  input logic       c_sgn,
  input logic       neg_addend,
  input logic       neg_result,
  input logic       out_valid,
  input logic [1:0] res_cls,
  input logic       res_sgn,
  input logic       invalid,
  input logic       nan_req,
  input logic       to_datapath
);
  // R2: out_valid tracks in_valid one cycle later.
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_cls));

  // R3: any NaN operand yields a request and nothing else.
  a_r3_nan_request: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a_cls == 2'd3 || b_cls == 2'd3 || c_cls == 2'd3))
    |=> (nan_req && !invalid && !to_datapath));

  // R3/R4/R12: the three outcome flags are mutually exclusive.
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({nan_req, invalid, to_datapath}));

  // R4: an invalid result is always the positive default NaN.
  a_r4_invalid_dnan: assert property (@(posedge clk) disable iff (rst)
    (out_valid && invalid) |-> (res_cls == 2'd3 && !res_sgn));

  // R12: a datapath handoff is always class normal.
  a_r12_dp_class: assert property (@(posedge clk) disable iff (rst)
    (out_valid && to_datapath) |-> (res_cls == 2'd1));

  // R7: two normal multiplicands and an infinite addend give a signed infinity.
  a_r7_inf_addend: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_cls == 2'd1 && b_cls == 2'd1 && c_cls == 2'd2)
    |=> (res_cls == 2'd2 && res_sgn == $past(c_sgn ^ neg_addend ^ neg_result)));
endmodule

bind fma_special_resolve fma_special_resolve_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .a_cls       (a_cls),
  .b_cls       (b_cls),
  .c_cls       (c_cls),
  .c_sgn       (c_sgn),
  .neg_addend  (neg_addend),
  .neg_result  (neg_result),
  .out_valid   (out_valid),
  .res_cls     (res_cls),
  .res_sgn     (res_sgn),
  .invalid     (invalid),
  .nan_req     (nan_req),
  .to_datapath (to_datapath)
);

// File: tb/fma_special_resolve_bench.sv
module fma_special_resolve_bench;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam logic [1:0] ZR = 2'd0, NM = 2'd1, IF = 2'd2, NN = 2'd3;
  localparam logic [EXP_W-1:0]  EMAX = {EXP_W{1'b1}};
  localparam logic [FRAC_W-1:0] DNF  = {1'b1, {(FRAC_W-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] a_cls = '0, b_cls = '0, c_cls = '0;
  logic a_sgn = 1'b0, b_sgn = 1'b0, c_sgn = 1'b0;
  logic [EXP_W-1:0]  c_exp = '0;
  logic [FRAC_W-1:0] c_frac = '0;
  logic neg_addend = 1'b0, neg_product = 1'b0, neg_result = 1'b0, halve_result = 1'b0;
  logic [1:0] rnd_mode = '0;
  logic out_valid, res_sgn, invalid, nan_req, to_datapath;
  logic [1:0] res_cls;
  logic [EXP_W-1:0]  res_exp;
  logic [FRAC_W-1:0] res_frac;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fma_special_resolve #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fma_special_resolve (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_cls(a_cls), .a_sgn(a_sgn), .b_cls(b_cls), .b_sgn(b_sgn),
    .c_cls(c_cls), .c_sgn(c_sgn), .c_exp(c_exp), .c_frac(c_frac),
    .neg_addend(neg_addend), .neg_product(neg_product),
    .neg_result(neg_result), .halve_result(halve_result), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .res_cls(res_cls), .res_sgn(res_sgn),
    .res_exp(res_exp), .res_frac(res_frac), .invalid(invalid),
    .nan_req(nan_req), .to_datapath(to_datapath)
  );

  // Drive one operation on a falling edge; outputs are read at the next falling edge.
  task automatic issue(input logic [1:0] ac, input logic as_, input logic [1:0] bc,
                       input logic bs, input logic [1:0] cc, input logic cs,
                       input logic [EXP_W-1:0] ce, input logic [FRAC_W-1:0] cf,
                       input logic [3:0] fl, input logic [1:0] rm);
    @(negedge clk);
    a_cls = ac; a_sgn = as_; b_cls = bc; b_sgn = bs;
    c_cls = cc; c_sgn = cs; c_exp = ce; c_frac = cf;
    {neg_addend, neg_product, neg_result, halve_result} = fl;
    rnd_mode = rm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [1:0] ecls, input logic esgn,
                            input logic [EXP_W-1:0] eexp, input logic [FRAC_W-1:0] efrac,
                            input logic einv, input logic enr, input logic edp);
    n_run++;
    if (!(out_valid === 1'b1 && res_cls === ecls && res_sgn === esgn &&
          res_exp === eexp && res_frac === efrac && invalid === einv &&
          nan_req === enr && to_datapath === edp)) begin
      n_fail++;
      $display("FAIL %s: got v=%b cls=%0d s=%b e=%h f=%h inv=%b nr=%b dp=%b exp v=1 cls=%0d s=%b e=%h f=%h inv=%b nr=%b dp=%b",
               req, out_valid, res_cls, res_sgn, res_exp, res_frac, invalid, nan_req,
               to_datapath, ecls, esgn, eexp, efrac, einv, enr, edp);
    end
  endtask

  task automatic t_reset();
    n_run++;
    if (!(out_valid === 1'b0 && res_cls === 2'd0 && res_sgn === 1'b0 && res_exp === '0 &&
          res_frac === '0 && invalid === 1'b0 && nan_req === 1'b0 && to_datapath === 1'b0)) begin
      n_fail++;
      $display("FAIL R1: got v=%b cls=%0d inv=%b nr=%b dp=%b exp all zero",
               out_valid, res_cls, invalid, nan_req, to_datapath);
    end
  endtask

  task automatic t_nan();
    issue(NN, 1'b1, NM, 1'b1, NM, 1'b1, 8'h12, 23'h55, 4'b1111, 2'd2);
    expect_out("R3 a nan", NN, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
    issue(IF, 1'b0, ZR, 1'b0, NN, 1'b0, 8'h00, 23'h0, 4'b0010, 2'd0);
    expect_out("R3 c nan over inf*0", NN, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_inf_zero();
    issue(IF, 1'b1, ZR, 1'b0, NM, 1'b0, 8'h10, 23'h1, 4'b0010, 2'd0);
    expect_out("R4 inf*zero neg_result", NN, 1'b0, EMAX, DNF, 1'b1, 1'b0, 1'b0);
    issue(ZR, 1'b0, IF, 1'b0, IF, 1'b1, 8'h00, 23'h0, 4'b0000, 2'd0);
    expect_out("R4 zero*inf", NN, 1'b0, EMAX, DNF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_inf_cancel();
    issue(IF, 1'b0, NM, 1'b0, IF, 1'b0, 8'h00, 23'h0, 4'b1000, 2'd0);
    expect_out("R5 cancel via neg_addend", NN, 1'b0, EMAX, DNF, 1'b1, 1'b0, 1'b0);
    issue(IF, 1'b0, NM, 1'b1, IF, 1'b0, 8'h00, 23'h0, 4'b0100, 2'd0);
    expect_out("R6 same sign via neg_product", IF, 1'b0, EMAX, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_inf_prod();
    issue(NM, 1'b1, IF, 1'b0, NM, 1'b0, 8'h20, 23'h3, 4'b0000, 2'd0);
    expect_out("R6 inf product", IF, 1'b1, EMAX, '0, 1'b0, 1'b0, 1'b0);
    issue(NM, 1'b1, IF, 1'b0, ZR, 1'b0, 8'h00, 23'h0, 4'b0110, 2'd0);
    expect_out("R6 R11 neg_product neg_result", IF, 1'b1, EMAX, '0, 1'b0, 1'b0, 1'b0);
    issue(IF, 1'b0, IF, 1'b0, NM, 1'b0, 8'h20, 23'h0, 4'b0001, 2'd0);
    expect_out("R10 halve ignored on inf", IF, 1'b0, EMAX, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_inf_add();
    issue(NM, 1'b0, ZR, 1'b0, IF, 1'b0, 8'h00, 23'h0, 4'b1000, 2'd0);
    expect_out("R7 zero prod inf addend neg_addend", IF, 1'b1, EMAX, '0, 1'b0, 1'b0, 1'b0);
    issue(NM, 1'b0, NM, 1'b1, IF, 1'b1, 8'h00, 23'h0, 4'b0010, 2'd0);
    expect_out("R7 R11 normal prod inf addend", IF, 1'b0, EMAX, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_pass();
    issue(ZR, 1'b1, NM, 1'b0, NM, 1'b0, 8'h40, 23'h123, 4'b0000, 2'd0);
    expect_out("R8 pass addend", NM, 1'b0, 8'h40, 23'h123, 1'b0, 1'b0, 1'b0);
    issue(NM, 1'b0, ZR, 1'b0, NM, 1'b0, 8'h40, 23'h123, 4'b0001, 2'd0);
    expect_out("R10 halve pass", NM, 1'b0, 8'h3F, 23'h123, 1'b0, 1'b0, 1'b0);
    issue(ZR, 1'b0, ZR, 1'b0, NM, 1'b0, 8'h81, 23'h7FFFFF, 4'b1010, 2'd0);
    expect_out("R8 R11 neg_addend neg_result", NM, 1'b0, 8'h81, 23'h7FFFFF, 1'b0, 1'b0, 1'b0);
    issue(ZR, 1'b0, NM, 1'b0, NM, 1'b0, 8'h81, 23'h5, 4'b0010, 2'd0);
    expect_out("R11 neg_result pass", NM, 1'b1, 8'h81, 23'h5, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_zero();
    issue(ZR, 1'b0, NM, 1'b1, ZR, 1'b0, 8'h00, 23'h0, 4'b0000, 2'd0);
    expect_out("R9 opposite zeros nearest", ZR, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    issue(ZR, 1'b0, NM, 1'b1, ZR, 1'b0, 8'h00, 23'h0, 4'b0000, 2'd2);
    expect_out("R9 opposite zeros down", ZR, 1'b1, '0, '0, 1'b0, 1'b0, 1'b0);
    issue(ZR, 1'b0, NM, 1'b1, ZR, 1'b0, 8'h00, 23'h0, 4'b0000, 2'd3);
    expect_out("R9 opposite zeros up", ZR, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    issue(ZR, 1'b1, NM, 1'b0, ZR, 1'b1, 8'h00, 23'h0, 4'b0000, 2'd0);
    expect_out("R9 matching negative zeros", ZR, 1'b1, '0, '0, 1'b0, 1'b0, 1'b0);
    issue(ZR, 1'b0, ZR, 1'b0, ZR, 1'b0, 8'h00, 23'h0, 4'b1011, 2'd2);
    expect_out("R9 R10 R11 down negate halve", ZR, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_datapath();
    issue(NM, 1'b1, NM, 1'b0, NM, 1'b0, 8'h33, 23'h44, 4'b0011, 2'd0);
    expect_out("R12 normal operands", NM, 1'b1, '0, '0, 1'b0, 1'b0, 1'b1);
    issue(NM, 1'b1, NM, 1'b0, ZR, 1'b0, 8'h00, 23'h0, 4'b0100, 2'd2);
    expect_out("R12 zero addend", NM, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_idle();
    logic [1:0] held;
    issue(IF, 1'b0, NM, 1'b0, NM, 1'b0, 8'h01, 23'h0, 4'b0000, 2'd0);
    held = res_cls;
    @(negedge clk);
    n_run++;
    if (!(out_valid === 1'b0 && res_cls === held && res_cls === IF)) begin
      n_fail++;
      $display("FAIL R2: got v=%b cls=%0d exp v=0 cls=%0d", out_valid, res_cls, IF);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nan();
    t_inf_zero();
    t_inf_cancel();
    t_inf_prod();
    t_inf_add();
    t_pass();
    t_zero();
    t_datapath();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end
endmodule